// File: doc/BRIEF.md
# Eight-Phase Frame Aligner with Rotation Estimate

This block watches a stream of received eight-phase symbols. Each symbol arrives already reduced to a 3-bit phase index. It searches for the position of a fixed frame header inside that stream. The header is held as a parameter bit word, and each header bit stands for a reference phase: a 0 bit is phase index 0 and a 1 bit is phase index 4, which is half a turn.

The block keeps the last N accepted symbols in a sliding window. For every new symbol it takes, for each window position, the difference between the received phase index and the reference phase index, modulo 8. A small table turns each difference into signed cosine and sine weights, so received amplitude plays no part. The weights are summed in a registered adder tree, giving a real sum and an imaginary sum.

Two run-time thresholds then decide two things from the same pair of sums in one step: whether the header is aligned, and by how many eighths of a turn the received constellation is rotated. A hit gives a one-cycle peak pulse and a 3-bit rotation index. Downstream logic uses the pulse to mark frame starts and the index to undo the rotation.

Top module: `psk8_frame_sync`

## Requirements
- R1: Term weights on a 256 scale, indexed by the phase difference d = (received − reference) mod 8:
  - cosine: 256, 181, 0, −181, −256, −181, 0, 181 for d = 0..7;
  - sine: 0, 181, 256, 181, 0, −181, −256, −181 for d = 0..7.
  - Header bit i (a 0 bit is reference phase 0, a 1 bit is reference phase 4) is paired with the symbol accepted i-th among the last N accepted symbols, counting from the oldest.
- R2: When a hit occurs, `peakPulse` is high for exactly one cycle. That cycle is the one following the clock edge that comes 2 + log2(N) edges after the edge that accepted the last header symbol.
- R3: Let |Re| and |Im| be the magnitudes of the two sums. If the R4 condition does not hold, and |Re| > `thrEven` or |Im| > `thrEven`, a hit is declared with an even index. The real part is examined first: if |Re| > `thrEven`, the index is 0 when Re is positive and 4 otherwise. Only when |Re| does not exceed `thrEven` is the imaginary part used: the index is 2 when Im is positive and 6 otherwise.
- R4: If |Re| > `thrOdd` and |Im| > `thrOdd`, a hit is declared with an odd index set by the signs of (Re, Im): (+,+)→1, (−,+)→3, (−,−)→5, (+,−)→7.
- R5: When the R3 and R4 conditions hold for the same window, the odd decision of R4 is reported.
- R6: Both comparisons are strict. A magnitude exactly equal to a threshold does not count as a hit.
- R7: An aligned header with k symbols inverted by half a turn still gives sums of magnitude (N − 2k)·256 on an even axis, or (N − 2k)·181 on each axis for an odd rotation. The header is therefore found while those magnitudes stay above the thresholds.
- R8: Cycles with `symValid` low neither shift the window nor produce a decision, whatever `symPhase` carries.
- R9: No peak is produced until at least N symbols have been accepted since reset.
- R10: A synchronous reset empties the window and the pipeline, drives `peakPulse` low and sets `ambIdx` to 0.
- R11: `ambIdx` keeps its last reported value until the next hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| symValid | input | 1 | A symbol is offered this cycle |
| symPhase | input | 3 | Received phase index in eighths of a turn |
| thrEven | input | THR_W | Single-axis threshold for even rotations |
| thrOdd | input | THR_W | Two-axis threshold for odd rotations |
| peakPulse | output | 1 | One-cycle header alignment pulse |
| ambIdx | output | 3 | Rotation estimate in eighths of a turn, counterclockwise |

## Verification
The even-axis decision and the odd-diagonal decision can both become true for the same window. The bench provokes this with a header whose first half arrives unrotated and whose second half arrives rotated by a quarter turn. This puts about 4096 on both axes, which is above lowered thresholds of 4000 and 3000. The expected odd index 1 is compared both by the scoreboard and directly at `ambIdx`. In parallel, the checker requires that any window meeting the two-axis condition yields an odd index.

// File: rtl/psk8_sync_pkg.sv
package psk8_sync_pkg;

  // Width of one signed weight: holds -256..256
  localparam int TERM_W = 10;

  typedef struct packed {
    logic shiftEn;   // accept the offered symbol into the window
    logic decideEn;  // the sums now at the tree output belong to a full window
  } syncStrobe_t;

  function automatic logic signed [TERM_W-1:0] cosWeight(input logic [2:0] d);
    case (d)
      3'd0:    cosWeight = 10'sd256;
      3'd1:    cosWeight = 10'sd181;
      3'd2:    cosWeight = 10'sd0;
      3'd3:    cosWeight = -10'sd181;
      3'd4:    cosWeight = -10'sd256;
      3'd5:    cosWeight = -10'sd181;
      3'd6:    cosWeight = 10'sd0;
      default: cosWeight = 10'sd181;
    endcase
  endfunction

  function automatic logic signed [TERM_W-1:0] sinWeight(input logic [2:0] d);
    case (d)
      3'd0:    sinWeight = 10'sd0;
      3'd1:    sinWeight = 10'sd181;
      3'd2:    sinWeight = 10'sd256;
      3'd3:    sinWeight = 10'sd181;
      3'd4:    sinWeight = 10'sd0;
      3'd5:    sinWeight = -10'sd181;
      3'd6:    sinWeight = -10'sd256;
      default: sinWeight = -10'sd181;
    endcase
  endfunction

endpackage

// File: rtl/psk8_sync_window.sv
module psk8_sync_window
  import psk8_sync_pkg::*;
#(
  parameter int N = 32,
  parameter logic [N-1:0] HDR = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shiftEn,
  input  logic [2:0]               symPhase,
  output logic signed [TERM_W-1:0] termRe [N],
  output logic signed [TERM_W-1:0] termIm [N]
);

  // win[0] is the newest accepted symbol, win[N-1] the oldest
  logic [2:0] win [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      win <= '{default: 3'd0};
    end else if (shiftEn) begin
      win[0] <= symPhase;
      for (int k = 1; k < N; k++) win[k] <= win[k-1];
    end
  end

  // Header bit i meets the i-th oldest symbol of the window
  for (genvar i = 0; i < N; i++) begin : g_tap
    localparam logic [2:0] REF_PH = HDR[i] ? 3'd4 : 3'd0;
    logic [2:0] diff;
    assign diff = win[N-1-i] - REF_PH;

    always_ff @(posedge clk) begin
      if (rst) begin
        termRe[i] <= '0;
        termIm[i] <= '0;
      end else begin
        termRe[i] <= cosWeight(diff);
        termIm[i] <= sinWeight(diff);
      end
    end
  end

endmodule

// File: rtl/psk8_sync_tree.sv
module psk8_sync_tree #(
  parameter int N     = 32,
  parameter int IN_W  = 10,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [IN_W-1:0]  leaf [N],
  output logic signed [OUT_W-1:0] sum
);

  localparam int LV = $clog2(N);
  localparam int NP = 1 << LV;

  // One registered pairwise-add level per stage, leaves padded to a power of two
  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    logic signed [OUT_W-1:0] node [NP >> l];

    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < NP; j++) begin : g_j
        if (j < N) begin : g_real
          assign node[j] = {{(OUT_W-IN_W){leaf[j][IN_W-1]}}, leaf[j]};
        end else begin : g_pad
          assign node[j] = '0;
        end
      end
    end else begin : g_add
      always_ff @(posedge clk) begin
        if (rst) begin
          node <= '{default: '0};
        end else begin
          for (int j = 0; j < (NP >> l); j++)
            node[j] <= g_lvl[l-1].node[2*j] + g_lvl[l-1].node[2*j+1];
        end
      end
    end
  end

  assign sum = g_lvl[LV].node[0];

endmodule

// File: rtl/psk8_sync_decide.sv
module psk8_sync_decide #(
  parameter int SUM_W = 16,
  parameter int THR_W = 15
) (
  input  logic signed [SUM_W-1:0] sumRe,
  input  logic signed [SUM_W-1:0] sumIm,
  input  logic [THR_W-1:0]        thrEven,
  input  logic [THR_W-1:0]        thrOdd,
  output logic                    hit,
  output logic [2:0]              lVal
);

  logic             negRe, negIm;
  logic [SUM_W-1:0] magRe, magIm, limEven, limOdd;
  logic             overRe, overIm, diagHit;

  assign negRe   = sumRe[SUM_W-1];
  assign negIm   = sumIm[SUM_W-1];
  assign magRe   = negRe ? SUM_W'(-sumRe) : SUM_W'(sumRe);
  assign magIm   = negIm ? SUM_W'(-sumIm) : SUM_W'(sumIm);
  assign limEven = SUM_W'(thrEven);
  assign limOdd  = SUM_W'(thrOdd);

  assign overRe  = magRe > limEven;
  assign overIm  = magIm > limEven;
  assign diagHit = (magRe > limOdd) && (magIm > limOdd);
  assign hit     = diagHit || overRe || overIm;

  always_comb begin
    if (diagHit) begin
      case ({negRe, negIm})
        2'b00:   lVal = 3'd1;
        2'b10:   lVal = 3'd3;
        2'b11:   lVal = 3'd5;
        default: lVal = 3'd7;
      endcase
    end else if (overRe) begin
      lVal = negRe ? 3'd4 : 3'd0;
    end else begin
      lVal = negIm ? 3'd6 : 3'd2;
    end
  end

endmodule

// File: rtl/psk8_sync_dp.sv
module psk8_sync_dp
  import psk8_sync_pkg::*;
#(
  parameter int N = 32,
  parameter logic [N-1:0] HDR = '0,
  parameter int SUM_W = 16,
  parameter int THR_W = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  syncStrobe_t             strobe,
  input  logic [2:0]              symPhase,
  input  logic [THR_W-1:0]        thrEven,
  input  logic [THR_W-1:0]        thrOdd,
  output logic signed [SUM_W-1:0] sumRe,
  output logic signed [SUM_W-1:0] sumIm,
  output logic                    peakPulse,
  output logic [2:0]              ambIdx
);

  logic signed [TERM_W-1:0] termRe [N];
  logic signed [TERM_W-1:0] termIm [N];
  logic                     hit;
  logic [2:0]               lVal;

  psk8_sync_window #(.N(N), .HDR(HDR)) u_win (
    .clk(clk), .rst(rst), .shiftEn(strobe.shiftEn), .symPhase(symPhase),
    .termRe(termRe), .termIm(termIm)
  );

  psk8_sync_tree #(.N(N), .IN_W(TERM_W), .OUT_W(SUM_W)) u_treeRe (
    .clk(clk), .rst(rst), .leaf(termRe), .sum(sumRe)
  );

  psk8_sync_tree #(.N(N), .IN_W(TERM_W), .OUT_W(SUM_W)) u_treeIm (
    .clk(clk), .rst(rst), .leaf(termIm), .sum(sumIm)
  );

  psk8_sync_decide #(.SUM_W(SUM_W), .THR_W(THR_W)) u_dec (
    .sumRe(sumRe), .sumIm(sumIm), .thrEven(thrEven), .thrOdd(thrOdd),
    .hit(hit), .lVal(lVal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      peakPulse <= 1'b0;
      ambIdx    <= 3'd0;
    end else begin
      peakPulse <= strobe.decideEn && hit;
      if (strobe.decideEn && hit) ambIdx <= lVal;
    end
  end

endmodule

// File: rtl/psk8_sync_ctl.sv
module psk8_sync_ctl
  import psk8_sync_pkg::*;
#(
  parameter int N = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        symValid,
  output syncStrobe_t strobe
);

  localparam int LV    = $clog2(N);
  localparam int CNT_W = $clog2(N + 1);
  localparam int PIPE  = LV + 2;  // term stage + tree levels + window stage

  logic [CNT_W-1:0] fillCnt;
  logic [PIPE-1:0]  vPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
      vPipe   <= '0;
    end else begin
      if (symValid && (fillCnt != CNT_W'(N))) fillCnt <= fillCnt + 1'b1;
      vPipe <= {vPipe[PIPE-2:0], symValid && (fillCnt >= CNT_W'(N - 1))};
    end
  end

  assign strobe.shiftEn  = symValid;
  assign strobe.decideEn = vPipe[PIPE-1];

endmodule

// File: rtl/psk8_frame_sync.sv
module psk8_frame_sync
  import psk8_sync_pkg::*;
#(
  parameter int N = 32,
  parameter logic [N-1:0] HDR = 32'h2EC7CD21,
  localparam int LV    = $clog2(N),
  localparam int SUM_W = TERM_W + LV + 1,
  localparam int THR_W = SUM_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             symValid,
  input  logic [2:0]       symPhase,
  input  logic [THR_W-1:0] thrEven,
  input  logic [THR_W-1:0] thrOdd,
  output logic             peakPulse,
  output logic [2:0]       ambIdx
);

  syncStrobe_t             strobe;
  logic signed [SUM_W-1:0] sumRe, sumIm;
  logic                    decideEn;

  assign decideEn = strobe.decideEn;

  psk8_sync_ctl #(.N(N)) u_ctl (
    .clk(clk), .rst(rst), .symValid(symValid), .strobe(strobe)
  );

  psk8_sync_dp #(.N(N), .HDR(HDR), .SUM_W(SUM_W), .THR_W(THR_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .symPhase(symPhase),
    .thrEven(thrEven), .thrOdd(thrOdd), .sumRe(sumRe), .sumIm(sumIm),
    .peakPulse(peakPulse), .ambIdx(ambIdx)
  );

endmodule

// File: rtl/psk8_sync_chk.sv
module psk8_sync_chk #(
  parameter int N = 32,
  parameter int SUM_W = 16,
  parameter int THR_W = 15
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    symValid,
  input logic [THR_W-1:0]        thrEven,
  input logic [THR_W-1:0]        thrOdd,
  input logic signed [SUM_W-1:0] sumRe,
  input logic signed [SUM_W-1:0] sumIm,
  input logic                    decideEn,
  input logic                    peakPulse,
  input logic [2:0]              ambIdx
);

  localparam int CNT_W = $clog2(N + 1);

  logic [CNT_W-1:0] seenCnt;
  logic [SUM_W-1:0] aRe, aIm;
  logic             condOdd, condEven;

  always_ff @(posedge clk) begin
    if (rst) seenCnt <= '0;
    else if (symValid && (seenCnt != CNT_W'(N))) seenCnt <= seenCnt + 1'b1;
  end

  assign aRe      = sumRe[SUM_W-1] ? SUM_W'(-sumRe) : SUM_W'(sumRe);
  assign aIm      = sumIm[SUM_W-1] ? SUM_W'(-sumIm) : SUM_W'(sumIm);
  assign condOdd  = (aRe > SUM_W'(thrOdd)) && (aIm > SUM_W'(thrOdd));
  assign condEven = (aRe > SUM_W'(thrEven)) || (aIm > SUM_W'(thrEven));

  AST_ODD_WINS: assert property (@(posedge clk) disable iff (rst)
    decideEn && condOdd |=> peakPulse && ambIdx[0]);  // R5
  AST_EVEN_AXIS: assert property (@(posedge clk) disable iff (rst)
    decideEn && condEven && !condOdd |=> peakPulse && !ambIdx[0]);  // R3
  AST_BELOW_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
    decideEn && !condEven && !condOdd |=> !peakPulse);  // R6
  AST_PEAK_NEEDS_DECISION: assert property (@(posedge clk) disable iff (rst)
    peakPulse |-> $past(decideEn));  // R2
  AST_WINDOW_FILLED: assert property (@(posedge clk) disable iff (rst)
    peakPulse |-> seenCnt >= CNT_W'(N));  // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !peakPulse && ambIdx == 3'd0);  // R10
  AST_INDEX_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !peakPulse |-> $stable(ambIdx));  // R11

endmodule

bind psk8_frame_sync psk8_sync_chk #(.N(N), .SUM_W(SUM_W), .THR_W(THR_W)) u_chk (
  .clk(clk), .rst(rst), .symValid(symValid), .thrEven(thrEven), .thrOdd(thrOdd),
  .sumRe(sumRe), .sumIm(sumIm), .decideEn(decideEn),
  .peakPulse(peakPulse), .ambIdx(ambIdx)
);

// File: tb/psk8_frame_sync_tb.sv
module psk8_frame_sync_tb;

  localparam int N = 32;
  localparam logic [N-1:0] HDR = 32'h2EC7CD21;
  localparam int LAT = 2 + $clog2(N);
  localparam int THR_W = 10 + $clog2(N);
  localparam int CLK_P = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             symValid = 1'b0;
  logic [2:0]       symPhase = 3'd0;
  logic [THR_W-1:0] thrEven = THR_W'(5000);
  logic [THR_W-1:0] thrOdd = THR_W'(3536);
  logic             peakPulse;
  logic [2:0]       ambIdx;

  psk8_frame_sync #(.N(N), .HDR(HDR)) u_dut (
    .clk(clk), .rst(rst), .symValid(symValid), .symPhase(symPhase),
    .thrEven(thrEven), .thrOdd(thrOdd), .peakPulse(peakPulse), .ambIdx(ambIdx)
  );

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard
  int         qCyc[$];
  logic [2:0] qL[$];
  string      qTag[$];
  int nChk = 0, nFail = 0, pulseSeen = 0, pushCnt = 0;
  int pulse0 = 0, push0 = 0;
  logic [2:0] lastL = 3'd0;
  string curTag = "R1";
  bit done = 1'b0;

  // Reference model state
  logic [2:0] mWin [N];
  int mCnt = 0;

  function automatic int cosW(input int d);
    case (d & 7)
      0: return 256;  1: return 181;  2: return 0;    3: return -181;
      4: return -256; 5: return -181; 6: return 0;    default: return 181;
    endcase
  endfunction

  function automatic int sinW(input int d);
    case (d & 7)
      0: return 0;    1: return 181;  2: return 256;  3: return 181;
      4: return 0;    5: return -181; 6: return -256; default: return -181;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelAccept(input logic [2:0] p);
    int re, im, aRe, aIm, l;
    bit oddC, eRe, eIm;
    for (int k = N - 1; k > 0; k--) mWin[k] = mWin[k-1];
    mWin[0] = p;
    if (mCnt < N) mCnt++;
    if (mCnt < N) return;
    re = 0; im = 0;
    for (int i = 0; i < N; i++) begin
      int d;
      d = int'(mWin[N-1-i]) - (HDR[i] ? 4 : 0);   // R1 pairing
      re += cosW(d);
      im += sinW(d);
    end
    aRe = (re < 0) ? -re : re;
    aIm = (im < 0) ? -im : im;
    oddC = (aRe > int'(thrOdd)) && (aIm > int'(thrOdd));   // R4, strict per R6
    eRe  = aRe > int'(thrEven);                          // R3
    eIm  = aIm > int'(thrEven);
    if (oddC) begin                                      // R5: odd first
      if (re > 0) l = (im > 0) ? 1 : 7;
      else        l = (im > 0) ? 3 : 5;
    end else if (eRe) l = (re > 0) ? 0 : 4;
    else if (eIm)     l = (im > 0) ? 2 : 6;
    else return;
    qCyc.push_back(cyc + 1 + LAT);   // R2 timing
    qL.push_back(3'(l));
    qTag.push_back(curTag);
    pushCnt++;
    lastL = 3'(l);
  endtask

  task automatic sendSym(input logic [2:0] p);
    symValid = 1'b1;
    symPhase = p;
    modelAccept(p);
    @(negedge clk);
    symValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      symValid = 1'b0;
      symPhase = 3'($urandom_range(0, 7));   // R8: garbage while not valid
      @(negedge clk);
    end
  endtask

  task automatic filler(input int n, input int maxGap);
    for (int k = 0; k < n; k++) begin
      sendSym(3'($urandom_range(0, 7)));
      if (maxGap > 0) idle($urandom_range(0, maxGap));
    end
  endtask

  task automatic sendHeader(input int l, input logic [N-1:0] errMask, input int maxGap);
    for (int i = 0; i < N; i++) begin
      sendSym(3'((HDR[i] ? 4 : 0) + l + (errMask[i] ? 4 : 0)));
      if (maxGap > 0) idle($urandom_range(0, maxGap));
    end
  endtask

  task automatic resetDut();
    @(negedge clk);
    rst = 1'b1;
    symValid = 1'b0;
    repeat (2) @(negedge clk);
    qCyc.delete(); qL.delete(); qTag.delete();
    for (int k = 0; k < N; k++) mWin[k] = 3'd0;
    mCnt = 0;
    lastL = 3'd0;
    rst = 1'b0;
  endtask

  task automatic sceneStart(input string tag);
    curTag = tag;
    pulse0 = pulseSeen;
    push0 = pushCnt;
  endtask

  task automatic sceneEnd(input string tag);
    idle(LAT + 4);
    check({tag, " peak count"}, pulseSeen - pulse0, pushCnt - push0);
    check({"R11 index held ", tag}, int'(ambIdx), int'(lastL));
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst) begin
      while (qCyc.size() > 0 && qCyc[0] < cyc) begin
        nChk++; nFail++;
        $display("FAIL R2 (%s) missed peak: actual=none expected cycle=%0d", qTag[0], qCyc[0]);
        void'(qCyc.pop_front()); void'(qL.pop_front()); void'(qTag.pop_front());
      end
      if (peakPulse) begin
        pulseSeen++;
        nChk++;
        if (qCyc.size() == 0 || qCyc[0] != cyc) begin
          nFail++;
          $display("FAIL R2 unexpected peak: actual cycle=%0d expected cycle=%0d",
                   cyc, (qCyc.size() == 0) ? -1 : qCyc[0]);
        end else begin
          if (ambIdx !== qL[0]) begin
            nFail++;
            $display("FAIL %s rotation index: actual=%0d expected=%0d", qTag[0], ambIdx, qL[0]);
          end
          void'(qCyc.pop_front()); void'(qL.pop_front()); void'(qTag.pop_front());
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) mWin[k] = 3'd0;
    repeat (3) @(negedge clk);
    resetDut();
    check("R10 reset peak", int'(peakPulse), 0);
    check("R10 reset index", int'(ambIdx), 0);

    // R9: header tail only, window not yet full
    sceneStart("R9");
    for (int i = 1; i < N; i++) sendSym(HDR[i] ? 3'd4 : 3'd0);
    sceneEnd("R9");

    // R1/R3/R4: every rotation
    for (int l = 0; l < 8; l++) begin
      sceneStart((l % 2) ? "R4" : "R3");
      filler(40, 0);
      sendHeader(l, '0, 0);
      sceneEnd((l % 2) ? "R4" : "R3");
    end

    // R8: gaps with garbage phase
    sceneStart("R8");
    filler(10, 3);
    sendHeader(5, '0, 3);
    sceneEnd("R8");

    // R7: errored header symbols
    sceneStart("R7");
    filler(40, 0);
    sendHeader(2, (N'(1) << 3) | (N'(1) << 10) | (N'(1) << 20), 0);
    sceneEnd("R7");
    check("R7 three errors found", pushCnt - push0 > 0 ? 1 : 0, 1);
    sceneStart("R7");
    filler(40, 0);
    sendHeader(7, N'(32'h0101_1C11), 0);
    sceneEnd("R7");

    // R6: strict comparison at exactly the clean even magnitude
    thrOdd = THR_W'(32767);
    thrEven = THR_W'(8192);
    sceneStart("R6");
    filler(40, 0);
    sendHeader(0, '0, 0);
    sceneEnd("R6");
    check("R6 equal magnitude no peak", pulseSeen - pulse0, 0);
    thrEven = THR_W'(8191);
    sceneStart("R6");
    filler(40, 0);
    sendHeader(0, '0, 0);
    sceneEnd("R6");
    check("R6 one above threshold peak", pulseSeen - pulse0, 1);

    // R5: both decisions true together
    thrEven = THR_W'(4000);
    thrOdd = THR_W'(3000);
    sceneStart("R5");
    filler(40, 0);
    for (int i = 0; i < N; i++) sendSym(3'((HDR[i] ? 4 : 0) + ((i < N/2) ? 0 : 2)));
    sceneEnd("R5");
    check("R5 odd priority index", int'(ambIdx), 1);

    // R10: reset in the middle of a header
    thrEven = THR_W'(5000);
    thrOdd = THR_W'(3536);
    sceneStart("R10");
    for (int i = 0; i < 20; i++) sendSym(HDR[i] ? 3'd4 : 3'd0);
    resetDut();
    check("R10 mid reset index", int'(ambIdx), 0);
    for (int i = 20; i < N; i++) sendSym(HDR[i] ? 3'd4 : 3'd0);
    sceneEnd("R10");

    // R11: index held across later non-hitting traffic
    sceneStart("R11");
    filler(40, 0);
    sendHeader(3, '0, 0);
    filler(20, 1);
    sceneEnd("R11");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule